// File: doc/BRIEF.md
# Gated-Counter Pulse Height Digitizer

This block sequences a linear-discharge pulse-height converter and turns the length of its discharge gate into a channel number. When the analog front end flags an incoming pulse, the block enables charging of a holding capacitor. It keeps charging until a comparator reports that the capacitor has reached the pulse amplitude. At that instant it switches to a constant-current discharge and opens a counting gate. The gate stays open until a second comparator reports the capacitor empty, so the gate width, and with it the count, grows linearly with the pulse amplitude.

The block is clocked by the fast counting clock, so each clock cycle with the gate open adds one channel. Conversion time therefore grows with the channel number. The count saturates at the top channel and then reports an overflow. The final count is latched as the channel address with a one-cycle done strobe. A busy flag covers the dead time from the start of a conversion to the done strobe. Detect pulses that arrive while busy are dropped.

Top module: `gated_count_digitizer`

## Requirements
- R1: After reset, chargeEn, dischargeEn, gate, busy, done and overflow are 0 and channel is 0.
- R2: With busy low, pulseDetect high at a clock edge makes chargeEn and busy high from the next cycle.
- R3: chargeEn stays high for as long as chargeReached is low. In the cycle after chargeReached is seen high, chargeEn is low and both dischargeEn and gate are high.
- R4: gate always equals dischargeEn, and chargeEn is never high together with dischargeEn.
- R5: gate stays high until dischargeEmpty is seen high at an edge, and it is low from the next cycle.
- R6: For a gate open for G cycles with G at most 2^CNT_W-1, channel equals G.
- R7: For G greater than 2^CNT_W-1, channel saturates at 2^CNT_W-1 and overflow is 1. For G at most 2^CNT_W-1, including G equal to 2^CNT_W-1, overflow is 0.
- R8: done is high for exactly one cycle, the cycle right after the gate closes. channel and overflow take their new values in that same cycle and hold them until the next done.
- R9: busy is high from the cycle after detection through the done cycle, and low in the cycle after done.
- R10: A pulseDetect while busy has no effect on sequencing or on the result. chargeReached and dischargeEmpty outside their own phase leave all outputs unchanged.
- R11: The counter clears at the start of every conversion. A short conversion after a saturated one reports its own length and overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseDetect | input | 1 | Input pulse present |
| chargeReached | input | 1 | Capacitor voltage has reached the pulse amplitude |
| dischargeEmpty | input | 1 | Capacitor fully discharged |
| chargeEn | output | 1 | Enable capacitor charging |
| dischargeEn | output | 1 | Enable linear discharge |
| gate | output | 1 | Counting gate open |
| busy | output | 1 | Conversion in progress (dead time) |
| done | output | 1 | One-cycle result strobe |
| channel | output | CNT_W | Latched channel address |
| overflow | output | 1 | Latched saturation flag for the last result |

## Verification
The bench builds the block with CNT_W = 4, so the top channel is 15. This puts the full saturation boundary within reach of a few tens of cycles: gates of exactly 15 cycles, which give no overflow, and of 20 cycles, which saturate. The other tests cover a one-cycle gate, a mid-range gate, and a short conversion that follows an overflow. With the default 12-bit width, the same sequence would need gates of thousands of cycles.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  typedef struct packed {
    logic clearCount;
    logic countEn;
    logic latch;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHARGE = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_FINISH = 2'd3
  } phase_t;
endpackage

// File: rtl/gcd_control.sv
module gcd_control
  import gcd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pulseDetect,
  input  logic         chargeReached,
  input  logic         dischargeEmpty,
  output logic         chargeEn,
  output logic         dischargeEn,
  output logic         gate,
  output logic         busy,
  output logic         done,
  output ctrlStrobes_t strobes
);
  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      ST_IDLE:   if (pulseDetect)    phaseNext = ST_CHARGE;
      ST_CHARGE: if (chargeReached)  phaseNext = ST_DRAIN;
      ST_DRAIN:  if (dischargeEmpty) phaseNext = ST_FINISH;
      ST_FINISH:                     phaseNext = ST_IDLE;
      default:                       phaseNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= ST_IDLE;
    else       phase <= phaseNext;
  end

  assign chargeEn    = (phase == ST_CHARGE);
  assign dischargeEn = (phase == ST_DRAIN);
  assign gate        = (phase == ST_DRAIN);
  assign busy        = (phase != ST_IDLE);
  assign done        = (phase == ST_FINISH);

  always_comb begin
    strobes.clearCount = (phase == ST_IDLE) && pulseDetect;
    strobes.countEn    = (phase == ST_DRAIN);
    strobes.latch      = (phase == ST_DRAIN) && dischargeEmpty;
  end

  // Assertions guarding the sequencing
  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && pulseDetect) |=> (chargeEn && busy));
  assert_charge_exit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (chargeEn && chargeReached) |=> (gate && dischargeEn && !chargeEn));
  assert_charge_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (chargeEn && !chargeReached) |=> chargeEn);
  assert_phase_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(chargeEn && dischargeEn));
  assert_gate_close_R5: assert property (@(posedge clk) disable iff (!rstN)
    (gate && dischargeEmpty) |=> (!gate && done));
  assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (gate && !dischargeEmpty) |=> gate);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  assert_busy_cover_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
  import gcd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  output logic [CNT_W-1:0]   channel,
  output logic               overflow
);
  localparam logic [CNT_W-1:0] TOP_CH = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count, countNext;
  logic             ovfAcc, atTop;

  assign atTop     = (count == TOP_CH);
  assign countNext = atTop ? TOP_CH : count + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      ovfAcc <= 1'b0;
    end else if (strobes.clearCount) begin
      count  <= '0;
      ovfAcc <= 1'b0;
    end else if (strobes.countEn) begin
      count  <= countNext;
      ovfAcc <= ovfAcc | atTop;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      channel  <= '0;
      overflow <= 1'b0;
    end else if (strobes.latch) begin
      channel  <= countNext;
      overflow <= ovfAcc | atTop;
    end
  end

  // Assertions guarding the counter and the result register
  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.countEn && !strobes.clearCount && count == TOP_CH) |=> (count == TOP_CH));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latch && !ovfAcc && !atTop) |=> !overflow);
  assert_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCount |=> (count == '0));
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latch |=> ($stable(channel) && $stable(overflow)));
endmodule

// File: rtl/gated_count_digitizer.sv
module gated_count_digitizer
  import gcd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulseDetect,
  input  logic             chargeReached,
  input  logic             dischargeEmpty,
  output logic             chargeEn,
  output logic             dischargeEn,
  output logic             gate,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] channel,
  output logic             overflow
);
  ctrlStrobes_t strobes;

  gcd_control u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .pulseDetect    (pulseDetect),
    .chargeReached  (chargeReached),
    .dischargeEmpty (dischargeEmpty),
    .chargeEn       (chargeEn),
    .dischargeEn    (dischargeEn),
    .gate           (gate),
    .busy           (busy),
    .done           (done),
    .strobes        (strobes)
  );

  gcd_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .channel  (channel),
    .overflow (overflow)
  );

  assert_gate_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    gate == dischargeEn);
endmodule

// File: tb/sim_gated_count_digitizer.sv
`timescale 1ns/1ps
module sim_gated_count_digitizer;
  localparam int CNT_W = 4;
  localparam int TOP = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pulseDetect = 1'b0, chargeReached = 1'b0, dischargeEmpty = 1'b0;
  logic chargeEn, dischargeEn, gate, busy, done, overflow;
  logic [CNT_W-1:0] channel;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gated_count_digitizer #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .pulseDetect(pulseDetect),
    .chargeReached(chargeReached), .dischargeEmpty(dischargeEmpty),
    .chargeEn(chargeEn), .dischargeEn(dischargeEn), .gate(gate),
    .busy(busy), .done(done), .channel(channel), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    check({chargeEn, dischargeEn, gate, busy, done, overflow} == 6'b0,
          "R1 control outputs", {chargeEn, dischargeEn, gate, busy, done, overflow}, 0);
    check(channel == 0, "R1 channel", channel, 0);
  endtask

  // One full conversion with a gate of g cycles; noise drives pulseDetect while busy
  task automatic convert(input int g, input bit noise, input string tag);
    int expCh;
    bit expOv;
    bit gateOk;
    expCh = (g > TOP) ? TOP : g;
    expOv = (g > TOP);
    pulseDetect = 1'b1;
    step();
    check(chargeEn && busy && !gate, {tag, " R2 start"}, {chargeEn, busy, gate}, 3'b110);
    pulseDetect = noise;
    step();
    check(chargeEn && !gate, {tag, " R3 charge hold"}, chargeEn, 1);
    chargeReached = 1'b1;
    step();
    chargeReached = 1'b0;
    check(gate && dischargeEn && !chargeEn, {tag, " R3 R4 discharge start"},
          {gate, dischargeEn, chargeEn}, 3'b110);
    gateOk = 1'b1;
    for (int k = 1; k <= g; k++) begin
      if (!(gate && dischargeEn && busy && !done)) gateOk = 1'b0;
      dischargeEmpty = (k == g);
      step();
    end
    dischargeEmpty = 1'b0;
    check(gateOk, {tag, " R5 gate held"}, gateOk, 1);
    check(!gate && done && busy, {tag, " R5 R8 close"}, {gate, done, busy}, 3'b011);
    check(channel == expCh, {tag, " R6 R7 channel"}, channel, expCh);
    check(overflow == expOv, {tag, " R7 overflow"}, overflow, expOv);
    pulseDetect = 1'b0;
    step();
    check(!done && !busy, {tag, " R8 R9 after done"}, {done, busy}, 0);
    check(channel == expCh && overflow == expOv, {tag, " R8 result held"}, channel, expCh);
    step();
  endtask

  // Comparator flags while idle must not move anything (R10)
  task automatic testIdleNoise();
    logic [CNT_W-1:0] chBefore;
    chBefore = channel;
    chargeReached = 1'b1;
    dischargeEmpty = 1'b1;
    step();
    step();
    check({chargeEn, dischargeEn, gate, busy, done} == 5'b0, "R10 idle flags ignored",
          {chargeEn, dischargeEn, gate, busy, done}, 0);
    check(channel == chBefore, "R10 channel unchanged", channel, chBefore);
    chargeReached = 1'b0;
    dischargeEmpty = 1'b0;
    step();
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    step();
    step();
    testReset();
    rstN = 1'b1;
    step();
    testReset();
    convert(1, 1'b0, "min gate R6");
    convert(7, 1'b0, "mid gate R6");
    convert(TOP, 1'b0, "top channel R7");
    convert(20, 1'b0, "saturate R7");
    convert(3, 1'b0, "clear after overflow R11");
    convert(5, 1'b1, "pulse while busy R10");
    testIdleNoise();
    convert(2, 1'b0, "after idle noise R11");
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule